// File: doc/BRIEF.md
# Downstream Port Reset and High-Speed Chirp Negotiator

This block takes one downstream port of a hub from an empty socket to an enabled link. It watches the sampled line state that a receiver model reports. Once a device has held an idle level steadily for long enough, the block drives a bus reset. During that reset it listens for a device chirp K. If it finds one, it answers with an alternating hub chirp train and then finishes the reset window with plain SE0. When the window closes, the block enables the port and reports the negotiated speed with a one-cycle done pulse.

All timing runs from a 1 µs clock-enable tick, so every duration is a whole number of ticks set by a parameter. A reset request re-runs the bus reset on a port that is already enabled. A disconnect on an enabled port drops the port back to idle.

Line state input codes are 0 = SE0, 1 = J, 2 = K, 3 = SE1, 4 = chirp J, 5 = chirp K. Drive codes are 0 = released, 1 = SE0, 2 = chirp J, 3 = chirp K. Speed codes are 0 = none, 1 = low, 2 = full, 3 = high.

Top module: `dport_hs_negotiator`

## Requirements
- R1: From idle, the reset starts on the ATTACH_US-th tick during which the line has stayed at J (code 1) or at K (code 2) without interruption. Any SE0 or other state before that tick restarts the count.
- R2: The bus reset window is the span in which the drive output is not released (code 0). It lasts exactly RESET_US ticks.
- R3: A device chirp K (code 5) counts only if it is present on FILT_US consecutive ticks. A shorter chirp K leaves the drive at SE0 (code 1).
- R4: The hub drives chirp K (drive code 3) in the clock cycle after a recognised device chirp K ends.
- R5: Each hub chirp lasts exactly CHIRP_US ticks. The chirps alternate, starting with K, and chirp J (drive code 2) only ever follows chirp K.
- R6: A new K/J pair starts only if the pair plus GUARD_US still fits in the window. The SE0 tail after the last chirp J therefore lasts at least GUARD_US and less than GUARD_US + 2*CHIRP_US ticks. If even one pair does not fit, no hub chirp is driven.
- R7: The speed is high (3) after at least one complete K/J pair. Otherwise it is low (1) when the attach level was K, and full (2) when it was J. With a K attach, device chirps are ignored.
- R8: When the window ends, done is high for exactly one cycle, in the same cycle that port_en rises and speed becomes valid.
- R9: On an enabled port, SE0 held for DISC_US ticks clears port_en and the speed code and leaves the drive released. A shorter SE0 has no effect.
- R10: After reset, and whenever the port is disabled, the drive is released, port_en is 0 and the speed is 0.
- R11: A reset_req pulse on an enabled port starts a new reset window in the next cycle and clears the speed. In idle, reset_req is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle enable every microsecond |
| reset_req | input | 1 | Request a new bus reset on an enabled port |
| line_st | input | 3 | Sampled line state code |
| drv_st | output | 2 | Requested drive state code |
| port_en | output | 1 | Port enabled |
| speed | output | 2 | Negotiated speed code |
| done | output | 1 | One-cycle pulse when negotiation completes |

## Verification
The bench targets four corner cases, and each one shows a distinct failure if the design gets it wrong.

- **Attach count restart:** a one-cycle SE0 is placed in the middle of the attach count. A design that fails to restart the count would start the reset early.
- **Short device chirp:** a device chirp K one tick shorter than the filter is applied. A design with a loose filter would start chirping on a glitch.
- **Late device chirp:** a valid chirp K arrives too close to the end of the window. A design without the fit rule would chirp into the guard time or cut a pair short.
- **Disconnect threshold:** a disconnect SE0 of DISC_US-1 ticks must be ignored while one of DISC_US ticks must take effect. Getting this wrong shows as a port that drops on a keep-alive or never drops at all.

Chirp durations, strict K-first alternation, the reset window length and the tail length are all measured in ticks on every negotiation.

// File: rtl/dpn_pkg.sv
package dpn_pkg;

  // sampled line state codes
  localparam logic [2:0] LN_SE0 = 3'd0;
  localparam logic [2:0] LN_J   = 3'd1;
  localparam logic [2:0] LN_K   = 3'd2;
  localparam logic [2:0] LN_SE1 = 3'd3;
  localparam logic [2:0] LN_CJ  = 3'd4;
  localparam logic [2:0] LN_CK  = 3'd5;

  typedef enum logic [1:0] {
    DRV_REL = 2'd0,
    DRV_SE0 = 2'd1,
    DRV_CJ  = 2'd2,
    DRV_CK  = 2'd3
  } drv_e;

  typedef enum logic [1:0] {
    SPD_NONE = 2'd0,
    SPD_LOW  = 2'd1,
    SPD_FULL = 2'd2,
    SPD_HIGH = 2'd3
  } spd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_DEVK,
    ST_CHIRP,
    ST_TAIL,
    ST_EN
  } st_e;

  // true when one more K/J pair plus the guard still fits in the window
  function automatic logic pair_fits(logic [31:0] elapsed, logic [31:0] win_len,
                                     logic [31:0] chirp_len, logic [31:0] guard);
    return (elapsed + (chirp_len << 1) + guard) <= win_len;
  endfunction

  function automatic spd_e pick_speed(logic hs_done, logic low_pol);
    if (hs_done)      return SPD_HIGH;
    else if (low_pol) return SPD_LOW;
    else              return SPD_FULL;
  endfunction

endpackage

// File: rtl/dpn_hold_filter.sv
module dpn_hold_filter #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic cond,
  output logic hit
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  // fires on the LIMIT-th tick with cond held throughout
  assign hit = cond && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr || !cond)
      cnt <= '0;
    else if (tick && (cnt != LAST))
      cnt <= cnt + 1'b1;
  end

  AST_FLT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3

  AST_FLT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (cnt == '0)); // R1

endmodule

// File: rtl/dpn_window_timer.sv
module dpn_window_timer #(
  parameter int LEN = 15000,
  parameter int CW  = $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  output logic [CW-1:0] elapsed,
  output logic          expire
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  assign expire = run && tick && (elapsed == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= '0;
    else if (!run || expire)
      elapsed <= '0;
    else if (tick)
      elapsed <= elapsed + 1'b1;
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (elapsed <= LAST)); // R2

  AST_WIN_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (elapsed == '0)); // R2

endmodule

// File: rtl/dport_hs_negotiator.sv
module dport_hs_negotiator
  import dpn_pkg::*;
#(
  parameter int ATTACH_US = 100,
  parameter int RESET_US  = 15000,
  parameter int FILT_US   = 3,
  parameter int CHIRP_US  = 50,
  parameter int GUARD_US  = 200,
  parameter int DISC_US   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       reset_req,
  input  logic [2:0] line_st,
  output logic [1:0] drv_st,
  output logic       port_en,
  output logic [1:0] speed,
  output logic       done
);
  localparam int WIN_W = $clog2(RESET_US + 1);

  st_e  st;
  logic phase_k;
  logic hs_ok;
  logic ls_q;
  spd_e speed_q;
  logic done_q;
  drv_e drv;

  // named internal events
  logic [1:0]       att_hit;
  logic             devk_hit;
  logic             chirp_hit;
  logic             disc_hit;
  logic             win_exp;
  logic             in_win;
  logic [WIN_W-1:0] win_elapsed;
  logic [31:0]      ela_now;
  logic             fits_now;

  assign in_win = (st == ST_RESET) || (st == ST_DEVK) ||
                  (st == ST_CHIRP) || (st == ST_TAIL);

  // attach debounce, one filter per idle polarity (0: J, 1: K)
  for (genvar g = 0; g < 2; g++) begin : g_attach
    localparam logic [2:0] CODE = (g == 0) ? LN_J : LN_K;
    dpn_hold_filter #(.LIMIT(ATTACH_US)) u_att (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (us_tick),
      .clr  (1'b0),
      .cond ((st == ST_IDLE) && (line_st == CODE)),
      .hit  (att_hit[g])
    );
  end

  dpn_hold_filter #(.LIMIT(FILT_US)) u_devk (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (us_tick),
    .clr  (1'b0),
    .cond ((st == ST_RESET) && (line_st == LN_CK) && !ls_q),
    .hit  (devk_hit)
  );

  dpn_hold_filter #(.LIMIT(CHIRP_US)) u_chirp (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (us_tick),
    .clr  (chirp_hit),
    .cond (st == ST_CHIRP),
    .hit  (chirp_hit)
  );

  dpn_hold_filter #(.LIMIT(DISC_US)) u_disc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (us_tick),
    .clr  (1'b0),
    .cond ((st == ST_EN) && (line_st == LN_SE0)),
    .hit  (disc_hit)
  );

  dpn_window_timer #(.LEN(RESET_US), .CW(WIN_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (us_tick),
    .run    (in_win),
    .elapsed(win_elapsed),
    .expire (win_exp)
  );

  // elapsed count as it stands after this edge
  assign ela_now  = 32'(win_elapsed) + (us_tick ? 32'd1 : 32'd0);
  assign fits_now = pair_fits(ela_now, 32'(RESET_US), 32'(CHIRP_US), 32'(GUARD_US));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      phase_k <= 1'b1;
      hs_ok   <= 1'b0;
      ls_q    <= 1'b0;
      speed_q <= SPD_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          hs_ok <= 1'b0;
          if (att_hit[0]) begin
            ls_q <= 1'b0;
            st   <= ST_RESET;
          end else if (att_hit[1]) begin
            ls_q <= 1'b1;
            st   <= ST_RESET;
          end
        end
        ST_EN: begin
          if (disc_hit) begin
            st      <= ST_IDLE;
            speed_q <= SPD_NONE;
          end else if (reset_req) begin
            st      <= ST_RESET;
            speed_q <= SPD_NONE;
            hs_ok   <= 1'b0;
          end
        end
        default: begin
          if (win_exp) begin
            st      <= ST_EN;
            speed_q <= pick_speed(hs_ok, ls_q);
            done_q  <= 1'b1;
          end else begin
            case (st)
              ST_RESET: if (devk_hit) st <= ST_DEVK;
              ST_DEVK: begin
                if (line_st != LN_CK) begin
                  phase_k <= 1'b1;
                  st      <= fits_now ? ST_CHIRP : ST_TAIL;
                end
              end
              ST_CHIRP: begin
                if (chirp_hit) begin
                  if (phase_k) begin
                    phase_k <= 1'b0;
                  end else begin
                    hs_ok   <= 1'b1;
                    phase_k <= 1'b1;
                    if (!fits_now) st <= ST_TAIL;
                  end
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_RESET, ST_DEVK, ST_TAIL: drv = DRV_SE0;
      ST_CHIRP:                   drv = phase_k ? DRV_CK : DRV_CJ;
      default:                    drv = DRV_REL;
    endcase
  end

  assign drv_st  = drv;
  assign port_en = (st == ST_EN);
  assign speed   = speed_q;
  assign done    = done_q;

  AST_ATTACH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(att_hit)); // R1

  AST_J_AFTER_K: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_st == DRV_CJ) |-> ($past(drv_st) == DRV_CK || $past(drv_st) == DRV_CJ)); // R5

  AST_LS_NO_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |-> (drv_st != DRV_CK)); // R7

  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (port_en && speed != SPD_NONE)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_FELL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_en) |-> (speed == SPD_NONE)); // R9

  AST_OFF_NO_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (speed == SPD_NONE)); // R10

  AST_REQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && reset_req && line_st != LN_SE0) |=> (drv_st == DRV_SE0)); // R11

endmodule

// File: tb/dport_hs_negotiator_bench.sv
module dport_hs_negotiator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int ATT   = 20;
  localparam int RST   = 600;
  localparam int FILT  = 3;
  localparam int CHIRP = 20;
  localparam int GUARD = 100;
  localparam int DISC  = 2;
  localparam int WDOG  = 150000;

  localparam logic [2:0] L_SE0 = 3'd0, L_J = 3'd1, L_K = 3'd2, L_CK = 3'd5;
  localparam logic [1:0] D_REL = 2'd0, D_SE0 = 2'd1, D_CJ = 2'd2, D_CK = 2'd3;
  localparam logic [1:0] S_NONE = 2'd0, S_LOW = 2'd1, S_FULL = 2'd2, S_HIGH = 2'd3;

  typedef struct {
    logic [1:0] spd;
    bit         chirp;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       reset_req = 1'b0;
  logic [2:0] line_st = 3'd0;
  logic [1:0] drv_st;
  logic       port_en;
  logic [1:0] speed;
  logic       done;

  int   n_run = 0;
  int   n_fail = 0;
  int   tc = 0;
  int   cyc = 0;
  exp_t sb[$];
  int   exp_start = 0;
  bit   exp_start_v = 0;

  dport_hs_negotiator #(
    .ATTACH_US(ATT), .RESET_US(RST), .FILT_US(FILT),
    .CHIRP_US(CHIRP), .GUARD_US(GUARD), .DISC_US(DISC)
  ) u_dport_hs_negotiator (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .reset_req(reset_req),
    .line_st(line_st), .drv_st(drv_st), .port_en(port_en),
    .speed(speed), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int div = 0;
  always @(negedge clk) begin
    us_tick <= (div == TICK_DIV - 1);
    div <= (div == TICK_DIV - 1) ? 0 : div + 1;
  end

  always @(posedge clk) if (us_tick) tc <= tc + 1;

  task automatic chk(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d (tc=%0d)", req, act, expv, tc);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor: measures windows and chirps, pops the scoreboard on done
  logic [1:0] prev_drv = 2'd0;
  logic       prev_done = 1'b0;
  int rst_t0 = 0, ph_t0 = 0, tail_t0 = 0, nchirp = 0;
  bit tail_v = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      chk(0, "watchdog", cyc, WDOG);
      finish_run();
    end
    if (rst_n && drv_st != prev_drv) begin
      if (prev_drv == D_REL) begin
        rst_t0 = tc; nchirp = 0; tail_v = 0;
        if (exp_start_v) begin
          chk(tc == exp_start + ATT, "R1 attach count", tc - exp_start, ATT);
          exp_start_v = 0;
        end
      end
      if (prev_drv == D_CK || prev_drv == D_CJ)
        chk(tc - ph_t0 == CHIRP, "R5 chirp length", tc - ph_t0, CHIRP);
      if (drv_st == D_CJ)
        chk(prev_drv == D_CK, "R5 J follows K", int'(prev_drv), int'(D_CK));
      if (drv_st == D_CK || drv_st == D_CJ) begin
        ph_t0 = tc;
        nchirp++;
      end
      if (prev_drv == D_CJ && drv_st == D_SE0) begin
        tail_t0 = tc; tail_v = 1;
      end
      if (drv_st == D_REL) begin
        chk(tc - rst_t0 == RST, "R2 window length", tc - rst_t0, RST);
        if (tail_v)
          chk(tc - tail_t0 >= GUARD && tc - tail_t0 < GUARD + 2 * CHIRP,
              "R6 tail length", tc - tail_t0, GUARD);
      end
    end
    if (done) begin
      chk(port_en == 1'b1, "R8 enable with done", int'(port_en), 1);
      chk(!prev_done, "R8 single pulse", int'(prev_done), 0);
      if (sb.size() == 0) chk(0, "R7 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(speed == e.spd, "R7 speed", int'(speed), int'(e.spd));
        chk((nchirp > 0) == e.chirp, "R6 hub chirp present", nchirp, int'(e.chirp));
      end
    end
    prev_drv = drv_st;
    prev_done = done;
  end

  task automatic wait_tc(int t);
    while (tc < t) @(negedge clk);
  endtask

  task automatic wait_en();
    while (!port_en) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_win();
    while (drv_st == D_REL) @(negedge clk);
  endtask

  task automatic expect_item(logic [1:0] s, bit c);
    exp_t e;
    e.spd = s; e.chirp = c;
    sb.push_back(e);
  endtask

  task automatic attach(logic [2:0] lvl);
    line_st = lvl;
    exp_start = tc;
    exp_start_v = 1;
  endtask

  // device chirp K of len ticks, starting dly ticks into the window
  task automatic dev_chirp(int dly, int len, logic [2:0] after, bit hub_answers, string req);
    int t;
    t = tc;
    wait_tc(t + dly);
    line_st = L_CK;
    t = tc;
    wait_tc(t + len);
    line_st = after;
    @(negedge clk);
    chk(drv_st == (hub_answers ? D_CK : D_SE0), req, int'(drv_st),
        int'(hub_answers ? D_CK : D_SE0));
  endtask

  task automatic unplug();
    int t;
    line_st = L_SE0;
    t = tc;
    wait_tc(t + DISC - 1);
    chk(port_en == 1'b1, "R9 before threshold", int'(port_en), 1);
    wait_tc(t + DISC);
    chk(port_en == 1'b0, "R9 port disabled", int'(port_en), 0);
    chk(speed == S_NONE, "R9 speed cleared", int'(speed), 0);
    chk(drv_st == D_REL, "R9 drive released", int'(drv_st), 0);
    wait_tc(tc + 3);
  endtask

  initial begin
    int t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv_st == D_REL && !port_en && speed == S_NONE && !done,
        "R10 reset state", int'(drv_st), 0);

    // R11: request in idle is ignored
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    wait_tc(tc + 3);
    chk(drv_st == D_REL, "R11 idle request ignored", int'(drv_st), 0);

    // R1: interrupted attach restarts the count, full speed result
    line_st = L_J;
    t = tc;
    wait_tc(t + ATT - 2);
    line_st = L_SE0;
    @(negedge clk);
    chk(drv_st == D_REL, "R1 no early reset", int'(drv_st), 0);
    expect_item(S_FULL, 0);
    attach(L_J);
    wait_en();
    chk(speed == S_FULL, "R7 full speed held", int'(speed), int'(S_FULL));

    // R9: short SE0 ignored
    line_st = L_SE0;
    t = tc;
    wait_tc(t + DISC - 1);
    line_st = L_J;
    wait_tc(tc + 4);
    chk(port_en == 1'b1 && speed == S_FULL, "R9 short SE0 ignored", int'(speed), int'(S_FULL));
    unplug();

    // R3/R4/R5/R6: high-speed exchange
    expect_item(S_HIGH, 1);
    attach(L_J);
    wait_win();
    dev_chirp(5, 10, L_J, 1, "R4 hub K after device K");
    wait_en();

    // R11: reset request on an enabled port
    expect_item(S_HIGH, 1);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk(drv_st == D_SE0 && !port_en, "R11 restart window", int'(drv_st), int'(D_SE0));
    chk(speed == S_NONE, "R11 speed cleared", int'(speed), 0);
    dev_chirp(40, 8, L_J, 1, "R4 hub K after device K again");
    wait_en();
    unplug();

    // R3: device chirp one tick short of the filter
    expect_item(S_FULL, 0);
    attach(L_J);
    wait_win();
    dev_chirp(5, FILT - 1, L_J, 0, "R3 short chirp ignored");
    wait_en();
    unplug();

    // R7: low-speed attach ignores device chirp
    expect_item(S_LOW, 0);
    attach(L_K);
    wait_win();
    dev_chirp(5, 10, L_K, 0, "R7 low speed no chirp");
    wait_en();
    unplug();

    // R6: device chirp too late for a pair
    expect_item(S_FULL, 0);
    attach(L_J);
    wait_win();
    dev_chirp(RST - GUARD - 2 * CHIRP + 5, 10, L_J, 0, "R6 late chirp not answered");
    wait_en();
    unplug();

    chk(sb.size() == 0, "R8 all results seen", sb.size(), 0);
    finish_run();
  end

endmodule